// File: doc/BRIEF.md
# Pipelined Bus Memory Slave with Programmable Wait States

This block is a slave on an AHB-style pipelined system bus. It holds a small array of words and answers reads and writes to it. Each transfer has a one-cycle address phase, in which the slave captures address, direction and size, and a data phase, in which the access happens. The data phase is stretched by a fixed number of wait cycles, set by a parameter. During those cycles the ready output is held low. The next transfer's address phase overlaps the current data phase and is stretched with it.

Writes may be a byte, a halfword or a full word. Per-byte lane enables come from the size and the low address bits, in little-endian order. A transfer that falls outside the array, is misaligned, or is wider than the bus gets a two-cycle ERROR response and changes nothing. IDLE and BUSY cycles, and cycles in which the slave is not selected, get an immediate OKAY.

A small state machine drives the data phase. Its states are:
- IDLE: no data phase is in progress.
- WAIT: counting wait cycles.
- DONE: the final OKAY cycle.
- ERR_LO: the first ERROR cycle, with ready low.
- ERR_HI: the second ERROR cycle, with ready high.

Its transitions are:
- From IDLE, DONE or ERR_HI, a captured transfer goes to ERR_LO if it is bad. A good one goes to WAIT, or straight to DONE when the wait count is 0. With no transfer captured, the machine returns to IDLE.
- WAIT goes to DONE when its counter reaches zero.
- ERR_LO always goes to ERR_HI.

Top module: `ahbw_mem_slave`

## Requirements
- R1: After reset, ready_o is 1, resp_o is OKAY (2'b00), rdata_o is 0 and every stored word is 0.
- R2: A cycle with trans_i IDLE (2'b00) or BUSY (2'b01), or with sel_i low, is ignored. The storage is not changed. The following cycle shows ready_o high with OKAY.
- R3: A good selected NONSEQ (2'b10) or SEQ (2'b11) transfer is captured on a clock edge where ready_in_i is high. Its data phase then shows ready_o low for exactly WAIT_CYCLES cycles, followed by one cycle with ready_o high and OKAY.
- R4: In the final cycle of a read, rdata_o carries the addressed word. In every other cycle rdata_o is 0.
- R5: size_i 0 is a byte, 1 a halfword and 2 a word. The write lane enables are little-endian. Byte k of the word is bits 8k+7:8k and is selected by addr_i[1:0]==k. A halfword at offset 2 covers bytes 2 and 3.
- R6: Write data is taken from wdata_i in the final data-phase cycle. Byte lanes that are not enabled keep their old value.
- R7: A transfer is bad if its word index (addr_i[31:2]) is DEPTH or more, if size_i is above 2, or if addr_i is not aligned to the size. A bad transfer answers ERROR (2'b01) for two cycles, the first with ready_o low and the second with ready_o high, and changes no stored word.
- R8: With ready_in_i low, nothing is captured. The following cycle shows ready_o high with OKAY.
- R9: Back-to-back transfers pipeline. The next address phase is captured on the edge that ends the current data phase, with no idle cycle between them.
- R10: The address and control inputs seen during wait cycles have no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Slave select from the address decoder |
| addr_i | input | ADDR_W | Byte address of the address phase |
| trans_i | input | 2 | Transfer type: IDLE 00, BUSY 01, NONSEQ 10, SEQ 11 |
| write_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 3 | log2 of the transfer size in bytes |
| wdata_i | input | DATA_W | Write data, valid during the data phase |
| ready_in_i | input | 1 | Bus-wide ready; high marks the end of the previous transfer |
| ready_o | output | 1 | This slave's ready; low inserts a wait cycle |
| resp_o | output | 2 | Response: OKAY 00, ERROR 01 |
| rdata_o | output | DATA_W | Read data, valid in the final read cycle |

## Verification
The assertions assume that ready_in_i follows ready_o whenever this slave owns the data phase, as the bus multiplexer makes it do. In other words, ready_in_i is never high while ready_o is low. The bench builds ready_in_i as ready_o, and pulls it low only while ready_o is already high, to model another slave's stall. The assertions also assume that the address and control inputs are valid in every address phase. The bench changes inputs only on falling edges, and holds each address phase until it is accepted.

// File: rtl/ahbw_pkg.sv
package ahbw_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam logic [1:0] RESP_ERROR = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WAIT   = 3'd1,
        ST_DONE   = 3'd2,
        ST_ERR_LO = 3'd3,
        ST_ERR_HI = 3'd4
    } phase_e;

endpackage

// File: rtl/ahbw_addr_check.sv
module ahbw_addr_check #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [2:0]                    size_i,
    output logic                          bad_o,
    output logic [DATA_W/8-1:0]           lane_en_o,
    output logic [$clog2(DEPTH)-1:0]      word_idx_o
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int HI_W  = ADDR_W - OFF_W;
    localparam logic [HI_W-1:0] DEPTH_V  = HI_W'(DEPTH);
    localparam logic [2:0]      MAX_SIZE = 3'(OFF_W);

    logic [HI_W-1:0] word_addr;
    logic            size_ok;
    logic            aligned;
    logic            in_range;
    int              nbytes;
    int              offset;

    always_comb begin
        word_addr = addr_i[ADDR_W-1:OFF_W];
        nbytes    = 1 << size_i;
        offset    = int'(addr_i[OFF_W-1:0]);
        size_ok   = (size_i <= MAX_SIZE);
        aligned   = ((offset & (nbytes - 1)) == 0);
        in_range  = (word_addr < DEPTH_V);
        bad_o     = !(size_ok && aligned && in_range);
    end

    assign word_idx_o = addr_i[OFF_W +: IDX_W];

    for (genvar l = 0; l < LANES; l++) begin : g_lane_en
        assign lane_en_o[l] = size_ok && (l >= offset) && (l < offset + nbytes);
    end

endmodule

// File: rtl/ahbw_regfile.sv
module ahbw_regfile #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [DATA_W/8-1:0]      lane_en_i,
    input  logic [$clog2(DEPTH)-1:0] idx_i,
    input  logic [DATA_W-1:0]        wdata_i,
    output logic [DATA_W-1:0]        rdata_o
);
    localparam int LANES = DATA_W / 8;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int w = 0; w < DEPTH; w++) begin
                    lane_mem[w] <= '0;
                end
            end else if (we_i && lane_en_i[l]) begin
                lane_mem[idx_i] <= wdata_i[8*l +: 8];
            end
        end

        assign rdata_o[8*l +: 8] = (int'(idx_i) < DEPTH) ? lane_mem[idx_i] : 8'h00;
    end

endmodule

// File: rtl/ahbw_ctrl.sv
module ahbw_ctrl
    import ahbw_pkg::*;
#(
    parameter int WAIT_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept_i,
    input  logic       bad_i,
    output logic       take_o,
    output logic       done_o,
    output logic       ready_o,
    output logic [1:0] resp_o
);
    localparam int CNT_W = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'((WAIT_CYCLES > 0) ? WAIT_CYCLES - 1 : 0);

    phase_e           state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             ready_state;

    assign ready_state = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_ERR_HI);
    assign take_o      = ready_state && accept_i;

    // next-state and counter logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE, ST_DONE, ST_ERR_HI: begin
                if (accept_i) begin
                    if (bad_i) begin
                        state_nx = ST_ERR_LO;
                    end else if (WAIT_CYCLES == 0) begin
                        state_nx = ST_DONE;
                    end else begin
                        state_nx = ST_WAIT;
                        cnt_nx   = LOAD_V;
                    end
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            ST_WAIT: begin
                if (cnt == '0) begin
                    state_nx = ST_DONE;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            ST_ERR_LO: state_nx = ST_ERR_HI;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        ready_o = 1'b1;
        resp_o  = RESP_OKAY;
        done_o  = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_WAIT:   ready_o = 1'b0;
            ST_DONE:   done_o  = 1'b1;
            ST_ERR_LO: begin
                ready_o = 1'b0;
                resp_o  = RESP_ERROR;
            end
            ST_ERR_HI: resp_o = RESP_ERROR;
            default:   ;
        endcase
    end

endmodule

// File: rtl/ahbw_mem_slave.sv
module ahbw_mem_slave
    import ahbw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int DEPTH       = 16,
    parameter int WAIT_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        trans_i,
    input  logic              write_i,
    input  logic [2:0]        size_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ready_in_i,
    output logic              ready_o,
    output logic [1:0]        resp_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int LANES = DATA_W / 8;
    localparam int IDX_W = $clog2(DEPTH);

    logic             accept, take, done, bad;
    logic [LANES-1:0] lane_en;
    logic [IDX_W-1:0] word_idx;
    logic             cap_write;
    logic [LANES-1:0] cap_lanes;
    logic [IDX_W-1:0] cap_idx;
    logic [DATA_W-1:0] mem_rdata;

    assign accept = sel_i && ready_in_i &&
                    ((trans_i == TR_NONSEQ) || (trans_i == TR_SEQ));

    ahbw_addr_check #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
    ) u_check (
        .addr_i     (addr_i),
        .size_i     (size_i),
        .bad_o      (bad),
        .lane_en_o  (lane_en),
        .word_idx_o (word_idx)
    );

    ahbw_ctrl #(
        .WAIT_CYCLES(WAIT_CYCLES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .bad_i    (bad),
        .take_o   (take),
        .done_o   (done),
        .ready_o  (ready_o),
        .resp_o   (resp_o)
    );

    // address-phase capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_write <= 1'b0;
            cap_lanes <= '0;
            cap_idx   <= '0;
        end else if (take) begin
            cap_write <= write_i;
            cap_lanes <= lane_en;
            cap_idx   <= word_idx;
        end
    end

    ahbw_regfile #(
        .DATA_W(DATA_W), .DEPTH(DEPTH)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (done && cap_write),
        .lane_en_i (cap_lanes),
        .idx_i     (cap_idx),
        .wdata_i   (wdata_i),
        .rdata_o   (mem_rdata)
    );

    assign rdata_o = (done && !cap_write) ? mem_rdata : '0;

endmodule

// File: rtl/ahbw_mem_slave_chk.sv
module ahbw_mem_slave_chk #(
    parameter int DATA_W      = 32,
    parameter int WAIT_CYCLES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_i,
    input logic [1:0]        trans_i,
    input logic              ready_in_i,
    input logic              ready_o,
    input logic [1:0]        resp_o,
    input logic [DATA_W-1:0] rdata_o
);
    logic [3:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!ready_o && resp_o == 2'b00) begin
            low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    // R7
    err_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_o == 2'b01 && !ready_o) |=> (resp_o == 2'b01 && ready_o));

    // R7
    err_first_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_o == 2'b01 && ready_o) |-> $past(resp_o == 2'b01 && !ready_o));

    // R2
    idle_zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && ready_in_i && (!sel_i || !trans_i[1])) |=> (ready_o && resp_o == 2'b00));

    // R8
    no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !ready_in_i) |=> (ready_o && resp_o == 2'b00));

    // R3
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && resp_o == 2'b00) |-> (low_run < 4'(WAIT_CYCLES)));

    // R4
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o) |-> (rdata_o == '0));

endmodule

bind ahbw_mem_slave ahbw_mem_slave_chk #(
    .DATA_W(DATA_W), .WAIT_CYCLES(WAIT_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel_i),
    .trans_i    (trans_i),
    .ready_in_i (ready_in_i),
    .ready_o    (ready_o),
    .resp_o     (resp_o),
    .rdata_o    (rdata_o)
);

// File: tb/tb_ahbw_mem_slave.sv
`timescale 1ns/1ps
module tb_ahbw_mem_slave;
    localparam int DEPTH = 16;
    localparam int WAITS = 2;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        sel_i = 0;
    logic [31:0] addr_i = 0;
    logic [1:0]  trans_i = 0;
    logic        write_i = 0;
    logic [2:0]  size_i = 0;
    logic [31:0] wdata_i = 0;
    logic        ready_in_i;
    logic        ready_o;
    logic [1:0]  resp_o;
    logic [31:0] rdata_o;
    logic        force_low = 0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;
    assign ready_in_i = force_low ? 1'b0 : ready_o;

    ahbw_mem_slave #(.DEPTH(DEPTH), .WAIT_CYCLES(WAITS)) dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .addr_i(addr_i),
        .trans_i(trans_i), .write_i(write_i), .size_i(size_i),
        .wdata_i(wdata_i), .ready_in_i(ready_in_i), .ready_o(ready_o),
        .resp_o(resp_o), .rdata_o(rdata_o)
    );

    typedef struct {
        int          waits;
        logic [1:0]  resp;
        logic [31:0] rdata;
        int          req;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] model [DEPTH];
    int          low_cnt = 0;

    task automatic check(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] lanes_of(input logic [1:0] off, input logic [2:0] sz);
        case (sz)
            3'd0:    return 4'b0001 << off;
            3'd1:    return off[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // monitor: pops one expected item per completed data phase
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ready_o) begin
                low_cnt++;
            end else if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(resp_o == e.resp, e.req, 32'(resp_o), 32'(e.resp));
                check(low_cnt == e.waits, e.req, 32'(low_cnt), 32'(e.waits));
                check(rdata_o == e.rdata, e.req, rdata_o, e.rdata);
                low_cnt = 0;
            end else begin
                low_cnt = 0;
            end
        end
    end

    // kind: 0 good, 1 bad (ERROR), 2 ignored
    task automatic xfer(input logic sel, input logic [1:0] tr, input logic [31:0] a,
                        input logic wr, input logic [2:0] sz, input logic [31:0] wd,
                        input int kind, input int req);
        exp_t e;
        sel_i = sel; trans_i = tr; addr_i = a; write_i = wr; size_i = sz;
        while (ready_in_i !== 1'b1) @(negedge clk);
        @(posedge clk);
        #1;
        wdata_i = wd;
        e.req = req;
        e.rdata = 32'h0;
        if (kind == 1) begin
            e.waits = 1; e.resp = 2'b01;
        end else if (kind == 2) begin
            e.waits = 0; e.resp = 2'b00;
        end else begin
            e.waits = WAITS; e.resp = 2'b00;
            if (wr) begin
                logic [3:0] ln;
                ln = lanes_of(a[1:0], sz);
                for (int k = 0; k < 4; k++)
                    if (ln[k]) model[a[31:2]][8*k +: 8] = wd[8*k +: 8];
            end else begin
                e.rdata = model[a[31:2]];
            end
        end
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic bus_idle();
        sel_i = 0; trans_i = 2'b00; write_i = 0;
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int w = 0; w < DEPTH; w++) model[w] = 32'h0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ready_o == 1'b1, 1, 32'(ready_o), 32'h1);
        check(resp_o == 2'b00, 1, 32'(resp_o), 32'h0);
        check(rdata_o == 32'h0, 1, rdata_o, 32'h0);
        rst_n = 1;
        @(negedge clk);
        check(ready_o == 1'b1 && resp_o == 2'b00, 1, 32'(ready_o), 32'h1);
        xfer(1, 2'b10, 32'h1C, 0, 3'd2, 32'h0, 0, 1);           // R1 memory zero

        // R3 R6 word write then read back
        xfer(1, 2'b10, 32'h00, 1, 3'd2, 32'h0, 0, 3);
        xfer(1, 2'b10, 32'h00, 1, 3'd2, 32'h11223344, 0, 6);
        xfer(1, 2'b10, 32'h00, 0, 3'd2, 32'h0, 0, 3);
        bus_idle();

        // R5 byte and halfword lanes, R6 other lanes held
        xfer(1, 2'b10, 32'h04, 1, 3'd2, 32'hA5A5A5A5, 0, 5);
        xfer(1, 2'b10, 32'h05, 1, 3'd0, 32'h0000AA00, 0, 5);
        xfer(1, 2'b10, 32'h0A, 1, 3'd1, 32'hBEEF0000, 0, 5);
        xfer(1, 2'b10, 32'h07, 1, 3'd0, 32'h77000000, 0, 6);
        xfer(1, 2'b10, 32'h04, 0, 3'd2, 32'h0, 0, 5);
        xfer(1, 2'b10, 32'h08, 0, 3'd2, 32'h0, 0, 5);
        bus_idle();

        // R2 IDLE, BUSY and deselected writes are ignored
        xfer(1, 2'b00, 32'h00, 1, 3'd2, 32'hFFFFFFFF, 2, 2);
        xfer(1, 2'b01, 32'h00, 1, 3'd2, 32'hFFFFFFFF, 2, 2);
        xfer(0, 2'b10, 32'h00, 1, 3'd2, 32'hFFFFFFFF, 2, 2);
        xfer(1, 2'b10, 32'h00, 0, 3'd2, 32'h0, 0, 2);
        bus_idle();

        // R7 errors: out of range, misaligned, oversize; storage untouched
        xfer(1, 2'b10, 32'(DEPTH * 4), 1, 3'd2, 32'hDEADBEEF, 1, 7);
        xfer(1, 2'b10, 32'h01, 1, 3'd1, 32'hDEADBEEF, 1, 7);
        xfer(1, 2'b10, 32'h02, 1, 3'd2, 32'hDEADBEEF, 1, 7);
        xfer(1, 2'b10, 32'h00, 1, 3'd3, 32'hDEADBEEF, 1, 7);
        xfer(1, 2'b10, 32'h00, 0, 3'd2, 32'h0, 0, 7);
        bus_idle();

        // R9 R10 back-to-back SEQ burst; next address held during waits
        xfer(1, 2'b10, 32'h30, 1, 3'd2, 32'hC0DE0000, 0, 9);
        xfer(1, 2'b11, 32'h34, 1, 3'd2, 32'hC0DE0001, 0, 9);
        xfer(1, 2'b11, 32'h38, 1, 3'd2, 32'hC0DE0002, 0, 10);
        xfer(1, 2'b11, 32'h3C, 1, 3'd2, 32'hC0DE0003, 0, 9);
        xfer(1, 2'b10, 32'h30, 0, 3'd2, 32'h0, 0, 10);
        xfer(1, 2'b11, 32'h34, 0, 3'd2, 32'h0, 0, 9);
        xfer(1, 2'b11, 32'h38, 0, 3'd2, 32'h0, 0, 9);
        xfer(1, 2'b11, 32'h3C, 0, 3'd2, 32'h0, 0, 10);           // R7 last valid index
        bus_idle();

        // R8 ready_in low blocks capture
        force_low = 1;
        sel_i = 1; trans_i = 2'b10; addr_i = 32'h0; write_i = 1; size_i = 3'd2;
        wdata_i = 32'h99999999;
        @(posedge clk);
        @(negedge clk);
        check(ready_o == 1'b1 && resp_o == 2'b00, 8, 32'(ready_o), 32'h1);
        sel_i = 0; trans_i = 2'b00; force_low = 0;
        @(negedge clk);
        check(ready_o == 1'b1 && resp_o == 2'b00, 8, 32'(ready_o), 32'h1);
        xfer(1, 2'b10, 32'h00, 0, 3'd2, 32'h0, 0, 8);
        bus_idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule